// File: doc/BRIEF.md
# Edge-Triggered Up/Down Counter Element

This block models the counter element of a ladder-logic controller in hardware. It holds a signed accumulator and a signed preset, both 16 bits wide by default. Two level inputs stand for the count-up and count-down rung conditions. Each input is edge-detected, so a rung that stays true adds or removes exactly one count. A registered done bit reports whether the accumulator has reached the preset in signed terms.

Counting never saturates. Stepping past the positive limit wraps the accumulator to the most negative value, and stepping past the negative limit wraps it to the most positive value. Each wrap sets a flag that stays set until the element is cleared. A synchronous clear input resets the element without resetting the chip. Two load ports write the accumulator and the preset directly. All words and status bits are visible on the outputs at all times.

Top module: `ctr_element`

## Requirements
- R1: While rst_ni is low, acc_o, pre_o, done_o, ovf_o, unf_o, cu_en_o and cd_en_o are all 0, with no clock edge needed.
- R2: A rising edge on up_rung_i adds 1 to acc_o at the same clock edge that first samples the input high. Holding the input high does not add further counts. A falling edge leaves acc_o unchanged.
- R3: A rising edge on dn_rung_i subtracts 1 from acc_o, with the same timing and hold behaviour as R2.
- R4: When both rungs show a rising edge in the same cycle, acc_o is left unchanged.
- R5: cu_en_o and cd_en_o show the level of up_rung_i and dn_rung_i as sampled at the previous clock edge. In a cycle where clr_i is sampled high, both bits are instead forced to 0.
- R6: An up count from 16'h7FFF gives 16'h8000 and sets ovf_o. ovf_o then stays set until clr_i or rst_ni.
- R7: A down count from 16'h8000 gives 16'h7FFF and sets unf_o. unf_o then stays set until clr_i or rst_ni.
- R8: done_o is registered. After every edge on which clr_i was low, it equals the signed compare acc_o >= pre_o, using the values that edge produced.
- R9: clr_i, sampled at a clock edge, sets acc_o to 0 and clears done_o, ovf_o, unf_o, cu_en_o and cd_en_o. It leaves pre_o unchanged. It wins over ld_acc_i and over any rung edge in the same cycle. A rung held high through the clear is not counted again.
- R10: ld_acc_i replaces acc_o with acc_data_i at the next edge. A rung edge in the same cycle is discarded. The load does not change ovf_o or unf_o.
- R11: ld_pre_i replaces pre_o with pre_data_i at the next edge, independently of any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the element |
| up_rung_i | input | 1 | Count-up rung condition (level) |
| dn_rung_i | input | 1 | Count-down rung condition (level) |
| ld_acc_i | input | 1 | Write accumulator |
| acc_data_i | input | 16 | Accumulator write value (signed) |
| ld_pre_i | input | 1 | Write preset |
| pre_data_i | input | 16 | Preset write value (signed) |
| acc_o | output | 16 | Accumulator (signed) |
| pre_o | output | 16 | Preset (signed) |
| cu_en_o | output | 1 | Count-up enable mirror |
| cd_en_o | output | 1 | Count-down enable mirror |
| done_o | output | 1 | Accumulator >= preset |
| ovf_o | output | 1 | Sticky overflow |
| unf_o | output | 1 | Sticky underflow |

## Verification
A stuck edge-history bit shows up at acc_o on the very next edge. It appears either as a second count while a rung is held high, or as a missing count on a new rising edge. A wrong done register or wrong wrap detection becomes visible on the edge that crosses the preset or a signed limit. The tests therefore step the accumulator across the preset in both directions and through both wrap points, and check every output one edge later. Sticky-flag faults only appear on later edges, so those flags are re-checked on idle cycles after they are set, and again after a load.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int unsigned NUM_RUNGS = 2;
  localparam int unsigned RUNG_UP   = 0;
  localparam int unsigned RUNG_DN   = 1;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_DEC,
    OP_LOAD,
    OP_CLR
  } acc_op_e;
endpackage

// File: rtl/ctr_rung_edge.sv
module ctr_rung_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] rung_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] en_o
);
  for (genvar g = 0; g < N; g++) begin : g_rung
    logic hist_q;
    logic en_q;

    // history is not cleared by clr_i, so a held rung never recounts
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= 1'b0;
      else         hist_q <= rung_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_q <= 1'b0;
      else if (clr_i) en_q <= 1'b0;
      else            en_q <= rung_i[g];
    end

    assign rise_o[g] = rung_i[g] & ~hist_q;
    assign en_o[g]   = en_q;

    // R2 / R3: one count per transition
    assert_single_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
    // R5
    assert_en_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !en_o[g]);
  end
endmodule

// File: rtl/ctr_accum.sv
module ctr_accum
  import ctr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_acc_i,
  input  logic [W-1:0] acc_d_i,
  input  logic         ld_pre_i,
  input  logic [W-1:0] pre_d_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] pre_o,
  output logic [W-1:0] acc_nxt_o,
  output logic [W-1:0] pre_nxt_o,
  output logic         wrap_hi_o,
  output logic         wrap_lo_o
);
  localparam logic [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE     = W'(1);

  acc_op_e      op;
  logic [W-1:0] acc_q, pre_q, acc_d, pre_d;

  always_comb begin
    if (clr_i)                op = OP_CLR;
    else if (ld_acc_i)        op = OP_LOAD;
    else if (inc_i && !dec_i) op = OP_INC;
    else if (dec_i && !inc_i) op = OP_DEC;
    else                      op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_CLR:  acc_d = '0;
      OP_LOAD: acc_d = acc_d_i;
      OP_INC:  acc_d = acc_q + ONE;
      OP_DEC:  acc_d = acc_q - ONE;
      default: acc_d = acc_q;
    endcase
    pre_d = ld_pre_i ? pre_d_i : pre_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      pre_q <= '0;
    end else begin
      acc_q <= acc_d;
      pre_q <= pre_d;
    end
  end

  assign wrap_hi_o = (op == OP_INC) && (acc_q == ACC_MAX);
  assign wrap_lo_o = (op == OP_DEC) && (acc_q == ACC_MIN);
  assign acc_o     = acc_q;
  assign pre_o     = pre_q;
  assign acc_nxt_o = acc_d;
  assign pre_nxt_o = pre_d;

  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_acc_i && inc_i && !dec_i) |=> acc_q == W'($past(acc_q) + ONE));
  assert_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_acc_i && dec_i && !inc_i) |=> acc_q == W'($past(acc_q) - ONE));
  assert_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_acc_i && inc_i && dec_i) |=> $stable(acc_q));
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0) && $stable(pre_q));
  assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_acc_i) |=> acc_q == $past(acc_d_i));
  assert_preset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_pre_i |=> pre_q == $past(pre_d_i));
endmodule

// File: rtl/ctr_status.sv
module ctr_status #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] acc_nxt_i,
  input  logic [W-1:0] pre_nxt_i,
  input  logic         wrap_hi_i,
  input  logic         wrap_lo_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] pre_i,
  output logic         done_o,
  output logic         ovf_o,
  output logic         unf_o
);
  logic done_q, ovf_q, unf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else if (clr_i) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      done_q <= $signed(acc_nxt_i) >= $signed(pre_nxt_i);
      ovf_q  <= ovf_q | wrap_hi_i;
      unf_q  <= unf_q | wrap_lo_i;
    end
  end

  assign done_o = done_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assert_done_cmp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(clr_i)) |-> done_q == ($signed(acc_i) >= $signed(pre_i)));
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
  assert_ovf_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_hi_i && !clr_i) |=> ovf_q);
  assert_unf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_q && !clr_i) |=> unf_q);
  assert_flags_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_q && !ovf_q && !unf_q);
endmodule

// File: rtl/ctr_element.sv
module ctr_element
  import ctr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         up_rung_i,
  input  logic         dn_rung_i,
  input  logic         ld_acc_i,
  input  logic [W-1:0] acc_data_i,
  input  logic         ld_pre_i,
  input  logic [W-1:0] pre_data_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] pre_o,
  output logic         cu_en_o,
  output logic         cd_en_o,
  output logic         done_o,
  output logic         ovf_o,
  output logic         unf_o
);
  logic [NUM_RUNGS-1:0] rung, rise, en;
  logic [W-1:0]         acc_nxt, pre_nxt;
  logic                 wrap_hi, wrap_lo;

  assign rung[RUNG_UP] = up_rung_i;
  assign rung[RUNG_DN] = dn_rung_i;

  ctr_rung_edge #(.N(NUM_RUNGS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .rung_i (rung),
    .rise_o (rise),
    .en_o   (en)
  );

  ctr_accum #(.W(W)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .ld_acc_i  (ld_acc_i),
    .acc_d_i   (acc_data_i),
    .ld_pre_i  (ld_pre_i),
    .pre_d_i   (pre_data_i),
    .inc_i     (rise[RUNG_UP]),
    .dec_i     (rise[RUNG_DN]),
    .acc_o     (acc_o),
    .pre_o     (pre_o),
    .acc_nxt_o (acc_nxt),
    .pre_nxt_o (pre_nxt),
    .wrap_hi_o (wrap_hi),
    .wrap_lo_o (wrap_lo)
  );

  ctr_status #(.W(W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .acc_nxt_i (acc_nxt),
    .pre_nxt_i (pre_nxt),
    .wrap_hi_i (wrap_hi),
    .wrap_lo_i (wrap_lo),
    .acc_i     (acc_o),
    .pre_i     (pre_o),
    .done_o    (done_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
  );

  assign cu_en_o = en[RUNG_UP];
  assign cd_en_o = en[RUNG_DN];

  assert_wrap_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wrap_hi && wrap_lo));
endmodule

// File: tb/ctr_element_tb.sv
`timescale 1ns/1ps
module ctr_element_tb;
  localparam int W = 16;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct packed {
    logic         clr;
    logic         lda;
    logic [15:0]  accd;
    logic         ldp;
    logic [15:0]  pred;
    logic         up;
    logic         dn;
    logic [15:0]  eacc;
    logic         edone;
    logic         eovf;
    logic         eunf;
    logic         ecu;
    logic         ecd;
  } vec_t;

  localparam int NV = 28;
  // expected values are the outputs one edge after the row is driven
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,16'h0000,1'b1,16'h0003,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0}, // R11 preset 3
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0001,1'b0,1'b0,1'b0,1'b1,1'b0}, // R2
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0001,1'b0,1'b0,1'b0,1'b1,1'b0}, // R2 held
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0001,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 fall
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0002,1'b0,1'b0,1'b0,1'b1,1'b0},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0002,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0003,1'b1,1'b0,1'b0,1'b1,1'b0}, // R8 reach
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0003,1'b1,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0004,1'b1,1'b0,1'b0,1'b1,1'b0}, // past preset
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b1,16'h0003,1'b1,1'b0,1'b0,1'b1,1'b1}, // R3 up held
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0003,1'b1,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b1,16'h0003,1'b1,1'b0,1'b0,1'b1,1'b1}, // R4
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0003,1'b1,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1,16'h0002,1'b0,1'b0,1'b0,1'b0,1'b1}, // R3 R8
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0002,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,16'h0000,1'b1,16'hFFFE,1'b0,1'b0,16'h0002,1'b1,1'b0,1'b0,1'b0,1'b0}, // R11 R8 signed
    '{1'b0,1'b1,16'h7FFF,1'b0,16'h0000,1'b1,1'b0,16'h7FFF,1'b1,1'b0,1'b0,1'b1,1'b0}, // R10 beats edge
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h7FFF,1'b1,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h8000,1'b0,1'b1,1'b0,1'b1,1'b0}, // R6 wrap
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h8000,1'b0,1'b1,1'b0,1'b0,1'b0}, // R6 sticky
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1,16'h7FFF,1'b1,1'b1,1'b1,1'b0,1'b1}, // R7 wrap
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h7FFF,1'b1,1'b1,1'b1,1'b0,1'b0}, // R7 sticky
    '{1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0}, // R9 clear
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b0}, // R9 no recount
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,16'hFFFD,1'b0,16'h0000,1'b0,1'b1,16'hFFFD,1'b0,1'b0,1'b0,1'b0,1'b1}, // R10
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'hFFFD,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,16'h0000,1'b1,16'hFFFD,1'b0,1'b0,16'hFFFD,1'b1,1'b0,1'b0,1'b0,1'b0}  // R8 equal
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_i = 1'b0, up_rung_i = 1'b0, dn_rung_i = 1'b0;
  logic         ld_acc_i = 1'b0, ld_pre_i = 1'b0;
  logic [W-1:0] acc_data_i = '0, pre_data_i = '0;
  logic [W-1:0] acc_o, pre_o;
  logic         cu_en_o, cd_en_o, done_o, ovf_o, unf_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  ctr_element #(.W(W)) u_dut (
    .clk_i, .rst_ni, .clr_i, .up_rung_i, .dn_rung_i,
    .ld_acc_i, .acc_data_i, .ld_pre_i, .pre_data_i,
    .acc_o, .pre_o, .cu_en_o, .cd_en_o, .done_o, .ovf_o, .unf_o
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    clr_i = 0; up_rung_i = 0; dn_rung_i = 0;
    ld_acc_i = 0; ld_pre_i = 0; acc_data_i = '0; pre_data_i = '0;
  endtask

  task automatic chk_all_zero(input string tag);
    chk({tag, " acc"},  32'(acc_o), 32'h0);
    chk({tag, " pre"},  32'(pre_o), 32'h0);
    chk({tag, " done"}, 32'(done_o), 32'h0);
    chk({tag, " ovf"},  32'(ovf_o), 32'h0);
    chk({tag, " unf"},  32'(unf_o), 32'h0);
    chk({tag, " cu"},   32'(cu_en_o), 32'h0);
    chk({tag, " cd"},   32'(cd_en_o), 32'h0);
  endtask

  initial begin
    logic [15:0] exp_pre;
    exp_pre = '0;
    idle_inputs();
    #1;
    chk_all_zero("R1 reset");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      clr_i = VECS[i].clr;
      ld_acc_i = VECS[i].lda;  acc_data_i = VECS[i].accd;
      ld_pre_i = VECS[i].ldp;  pre_data_i = VECS[i].pred;
      up_rung_i = VECS[i].up;  dn_rung_i = VECS[i].dn;
      if (VECS[i].ldp) exp_pre = VECS[i].pred;
      @(posedge clk_i);
      #1;
      chk($sformatf("row%0d acc R2 R3 R4 R6 R7 R9 R10", i), 32'(acc_o), 32'(VECS[i].eacc));
      chk($sformatf("row%0d pre R11", i), 32'(pre_o), 32'(exp_pre));
      chk($sformatf("row%0d done R8", i), 32'(done_o), 32'(VECS[i].edone));
      chk($sformatf("row%0d ovf R6", i), 32'(ovf_o), 32'(VECS[i].eovf));
      chk($sformatf("row%0d unf R7", i), 32'(unf_o), 32'(VECS[i].eunf));
      chk($sformatf("row%0d cu R5", i), 32'(cu_en_o), 32'(VECS[i].ecu));
      chk($sformatf("row%0d cd R5", i), 32'(cd_en_o), 32'(VECS[i].ecd));
    end

    // R9: clear wins over a load in the same cycle
    @(negedge clk_i);
    idle_inputs();
    clr_i = 1; ld_acc_i = 1; acc_data_i = 16'h1234;
    @(posedge clk_i); #1;
    chk("R9 clear over load acc", 32'(acc_o), 32'h0);
    chk("R9 preset kept", 32'(pre_o), 32'(exp_pre));

    // R10: a load leaves sticky flags alone; set ovf first
    @(negedge clk_i);
    idle_inputs(); ld_acc_i = 1; acc_data_i = 16'h7FFF;
    @(negedge clk_i);
    idle_inputs(); up_rung_i = 1;
    @(negedge clk_i);
    idle_inputs(); ld_acc_i = 1; acc_data_i = 16'h0005;
    @(posedge clk_i); #1;
    chk("R10 load value", 32'(acc_o), 32'h5);
    chk("R10 ovf kept through load", 32'(ovf_o), 32'h1);

    // R1: asynchronous reset mid-run, seen before any clock edge
    @(negedge clk_i);
    idle_inputs();
    ld_pre_i = 1; pre_data_i = 16'h0042;
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    #0.5;
    chk_all_zero("R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule